// File: doc/BRIEF.md
# Fractional UART baud generator

This block derives the two timing strobes an asynchronous serial port needs from a single peripheral clock. The first is a sample tick, the oversampling strobe that a receiver uses to find bit midpoints. The second is a bit tick, the strobe at the line bit rate. The average spacing of sample ticks is (M + N/2048) × DIV peripheral clock cycles. A bit tick fires once per 2^(OSR+2) sample ticks, so the bit rate is PCLK / ((M + N/2048) × 2^(OSR+2) × DIV).

The block has three stages in a chain.

- An integer counter produces one "pass" every DIV cycles.
- A fractional stage groups either M or M+1 passes into one sample period. An 11-bit phase accumulator picks the group size, so the long-run mean is exactly M + N/2048.
- An oversampling counter picks every 2^(OSR+2)-th sample tick as a bit tick.

Both strobes are one cycle wide. A transmitter or receiver consumes them directly.

All counters are held at zero while the enable is low. If any configuration field differs from its value in the previous cycle, all counters restart from zero.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is asserted, sample_tick_o and bit_tick_o are low.
- R2: With n_i = 0, successive sample ticks are exactly m_i × DIV cycles apart.
- R3: An 11-bit accumulator starts at zero and adds n_i once per sample period. The period is (m_i + c) × DIV cycles, where c is the carry out of that addition, and the accumulator keeps the sum modulo 2048. Over 2048 periods the total is therefore (2048 × m_i + n_i) × DIV cycles.
- R4: The 16-bit divisor field div_i selects DIV = div_i, except that the value 0 selects DIV = 65536.
- R5: While en_i is low, no strobe is produced and all counters are cleared. The cycle in which en_i is first seen high counts as cycle 1 of the first sample period, so the first sample tick comes L−1 clock edges later, where L is the period length.
- R6: bit_tick_o is high only together with sample_tick_o, on every 2^(osr_i+2)-th sample tick counted from a restart. The osr_i codes 0, 1, 2 and 3 give ratios of 4, 8, 16 and 32.
- R7: A clock cycle in which any of m_i, n_i, div_i or osr_i differs from the value in the previous cycle is a dead cycle. In that cycle all counters are zeroed, so the first sample tick after a change is seen L edges after the new value is applied.
- R8: An m_i value of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low clears and silences the generator |
| m_i | input | 2 | Integer part of the fractional multiplier (1..3; 0 acts as 1) |
| n_i | input | 11 | Fractional part of the multiplier, in units of 1/2048 |
| div_i | input | 16 | Integer divisor; 0 means 65536 |
| osr_i | input | 2 | Oversampling code; ratio is 2^(osr_i+2) |
| sample_tick_o | output | 1 | One-cycle oversampling strobe |
| bit_tick_o | output | 1 | One-cycle bit-rate strobe |

## Verification
The assertions assume that en_i and the configuration fields are synchronous to clk_i and are settled before each rising edge. They also assume that any change to a field is meant to restart the generator, which is the only situation in which counter state may jump. The stimulus drives every input on the falling edge. Each new setting differs from the one before it in at least one field, so that every scenario begins from a known restart. Enable-timing checks use periods of at least two cycles, which keeps the first tick from falling inside the cycle in which the enable is applied.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int M_W    = 2;
  localparam int FRAC_W = 11;
  localparam int DIV_W  = 16;
  localparam int OSR_W  = 2;

  typedef struct packed {
    logic [M_W-1:0]    m;
    logic [FRAC_W-1:0] n;
    logic [DIV_W-1:0]  div;
    logic [OSR_W-1:0]  osr;
  } fbg_cfg_t;
endpackage

// File: rtl/fbg_int_div.sv
module fbg_int_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             pass_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] term;

  // div_i == 0 wraps to all-ones: a full 2^DIV_W cycle pass
  assign term   = div_i - {{(DIV_W-1){1'b0}}, 1'b1};
  assign pass_o = run_i && (cnt_q == term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || pass_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + {{(DIV_W-1){1'b0}}, 1'b1};
  end

  p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !pass_o) |=> (cnt_q == $past(cnt_q) + {{(DIV_W-1){1'b0}}, 1'b1}));

  p_idle_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/fbg_frac_stage.sv
module fbg_frac_stage #(
  parameter int M_W    = 2,
  parameter int FRAC_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              pass_i,
  input  logic [M_W-1:0]    m_i,
  input  logic [FRAC_W-1:0] n_i,
  output logic              tick_o
);
  logic [FRAC_W-1:0] acc_q;
  logic [M_W-1:0]    pcnt_q;
  logic [FRAC_W:0]   sum;
  logic              extra;
  logic [M_W-1:0]    m_eff;
  logic [M_W-1:0]    last_idx;

  assign m_eff    = (m_i == '0) ? {{(M_W-1){1'b0}}, 1'b1} : m_i;
  assign sum      = {1'b0, acc_q} + {1'b0, n_i};
  assign extra    = sum[FRAC_W];
  // carry stretches this period by one extra divider pass
  assign last_idx = m_eff - {{(M_W-1){1'b0}}, 1'b1} + {{(M_W-1){1'b0}}, extra};
  assign tick_o   = pass_i && (pcnt_q == last_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      pcnt_q <= '0;
    end else if (!run_i) begin
      acc_q  <= '0;
      pcnt_q <= '0;
    end else if (tick_o) begin
      acc_q  <= sum[FRAC_W-1:0];
      pcnt_q <= '0;
    end else if (pass_i) begin
      pcnt_q <= pcnt_q + {{(M_W-1){1'b0}}, 1'b1};
    end
  end

  p_acc_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_o) |=> (acc_q == $past(acc_q)));

  p_pass_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (pcnt_q <= m_eff));
endmodule

// File: rtl/fbg_osr_stage.sv
module fbg_osr_stage #(
  parameter int OSR_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [OSR_W-1:0] osr_i,
  output logic             bit_o
);
  localparam int CNT_W = (1 << OSR_W) + 1;

  logic [CNT_W-1:0] scnt_q;
  logic [CNT_W:0]   ratio;
  logic [CNT_W-1:0] ratio_m1;

  assign ratio    = {{CNT_W{1'b0}}, 1'b1} << (32'(osr_i) + 32'd2);
  assign ratio_m1 = CNT_W'(ratio - {{CNT_W{1'b0}}, 1'b1});
  assign bit_o    = tick_i && (scnt_q == ratio_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              scnt_q <= '0;
    else if (!run_i || bit_o) scnt_q <= '0;
    else if (tick_i)          scnt_q <= scnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  p_scnt_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (scnt_q <= ratio_m1));
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [M_W-1:0]    m_i,
  input  logic [FRAC_W-1:0] n_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [OSR_W-1:0]  osr_i,
  output logic              sample_tick_o,
  output logic              bit_tick_o
);
  fbg_cfg_t cfg, cfg_q;
  logic     cfg_chg;
  logic     run;
  logic     pass;

  assign cfg     = '{m: m_i, n: n_i, div: div_i, osr: osr_i};
  assign cfg_chg = (cfg != cfg_q);
  assign run     = en_i && !cfg_chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg;
  end

  fbg_int_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .div_i  (div_i),
    .pass_o (pass)
  );

  fbg_frac_stage #(.M_W(M_W), .FRAC_W(FRAC_W)) u_frac (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .pass_i (pass),
    .m_i    (m_i),
    .n_i    (n_i),
    .tick_o (sample_tick_o)
  );

  fbg_osr_stage #(.OSR_W(OSR_W)) u_osr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_i (sample_tick_o),
    .osr_i  (osr_i),
    .bit_o  (bit_tick_o)
  );

  p_quiet_when_off_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!sample_tick_o && !bit_tick_o));

  p_bit_with_sample_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> sample_tick_o);

  p_restart_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_chg |=> !bit_tick_o);

  p_tick_needs_steady_cfg_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_tick_o |-> $stable(cfg));
endmodule

// File: tb/frac_baud_gen_tb.sv
module frac_baud_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  m = 2'd1;
  logic [10:0] n = '0;
  logic [15:0] dv = 16'd2;
  logic [1:0]  osr = '0;
  logic        stick, btick;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  frac_baud_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .m_i(m), .n_i(n),
    .div_i(dv), .osr_i(osr), .sample_tick_o(stick), .bit_tick_o(btick)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int mm, input int nn, input int dd, input int oo);
    @(negedge clk);
    m = 2'(mm); n = 11'(nn); dv = 16'(dd); osr = 2'(oo);
  endtask

  // counts falling edges until a sample tick is observed
  task automatic wait_tick(output int cyc, output bit bt);
    cyc = 0;
    bt  = 1'b0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!stick && cyc < 70000);
    bt = btick;
  endtask

  task automatic t_reset();
    int bad = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (stick || btick) bad++;
    end
    check(bad == 0, "R1 ticks low in reset", bad, 0);
  endtask

  task automatic t_integer();
    int c; bit b;
    set_cfg(2, 0, 3, 2);
    wait_tick(c, b);
    check(c == 6, "R7 latency after config change", c, 6);
    for (int i = 0; i < 4; i++) begin
      wait_tick(c, b);
      check(c == 6, "R2 integer interval", c, 6);
    end
  endtask

  task automatic frac_run(input int mm, input int nn, input int dd, input int cnt);
    int c, s, ex, acc, bad; bit b;
    acc = 0; bad = 0;
    set_cfg(mm, nn, dd, 2);
    for (int i = 0; i < cnt; i++) begin
      s   = acc + nn;
      ex  = (mm + ((s >= 2048) ? 1 : 0)) * dd;
      acc = s % 2048;
      wait_tick(c, b);
      if (c != ex) begin
        bad++;
        if (bad == 1) check(1'b0, "R3 fractional interval", c, ex);
      end
    end
    check(bad == 0, "R3 fractional sequence", bad, 0);
  endtask

  task automatic t_fraction_sum();
    int c, tot; bit b;
    tot = 0;
    set_cfg(1, 1365, 1, 2);
    for (int i = 0; i < 2048; i++) begin
      wait_tick(c, b);
      tot += c;
    end
    check(tot == 3413, "R3 2048-period total", tot, 3413);
  endtask

  task automatic t_m_zero();
    int c; bit b;
    set_cfg(0, 0, 4, 2);
    wait_tick(c, b);
    wait_tick(c, b);
    check(c == 4, "R8 m=0 acts as 1", c, 4);
  endtask

  task automatic t_osr();
    int c, r, bad; bit b;
    for (int o = 0; o < 4; o++) begin
      r = 1 << (o + 2);
      bad = 0;
      set_cfg(2, 0, 1, o);
      for (int i = 1; i <= 2 * r; i++) begin
        wait_tick(c, b);
        if (b != ((i % r) == 0)) bad++;
      end
      check(bad == 0, $sformatf("R6 bit ratio osr=%0d", o), bad, 0);
    end
  endtask

  task automatic t_enable();
    int c, bad; bit b;
    en = 1'b0;
    set_cfg(2, 0, 5, 0);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (stick || btick) bad++;
    end
    check(bad == 0, "R5 silent while disabled", bad, 0);
    en = 1'b1;
    wait_tick(c, b);
    check(c == 9, "R5 first tick after enable", c, 9);
    repeat (4) @(negedge clk);
    en = 1'b0;
    repeat (3) @(negedge clk);
    check(!stick && !btick, "R5 silent after disable", stick, 0);
    en = 1'b1;
    wait_tick(c, b);
    check(c == 9, "R5 counters cleared by disable", c, 9);
  endtask

  task automatic t_reconfig();
    int c, first_bit; bit b;
    set_cfg(1, 0, 7, 2);
    wait_tick(c, b);
    repeat (3) @(negedge clk);
    osr = 2'd1;
    wait_tick(c, b);
    check(c == 7, "R7 restart on osr-only change", c, 7);
    first_bit = b ? 1 : 0;
    for (int i = 2; i <= 8 && first_bit == 0; i++) begin
      wait_tick(c, b);
      if (b) first_bit = i;
    end
    check(first_bit == 8, "R7 osr counter restarted", first_bit, 8);
  endtask

  task automatic t_div_max();
    int c; bit b;
    set_cfg(1, 0, 0, 2);
    wait_tick(c, b);
    check(c == 65536, "R4 div=0 is 65536", c, 65536);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    en = 1'b1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_integer();
    frac_run(2, 700, 3, 12);
    frac_run(3, 2047, 2, 10);
    t_fraction_sum();
    t_m_zero();
    t_osr();
    t_enable();
    t_reconfig();
    t_div_max();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule